// File: doc/BRIEF.md
# Three-Channel TMDS Character Decoder

This block sits behind the deserialiser of a DVI-style video receiver. On every pixel clock it takes one word-aligned 10-bit TMDS character per lane: blue on lane 0, green on lane 1 and red on lane 2. It works out whether each character is a colour character or one of the four reserved control characters. From that it decides whether the link is in active video or in blanking, so no separate data-enable wire is needed on the link.

While all three lanes carry colour characters, each lane's 8-bit value is recovered and the three values are packed into a 24-bit pixel word. While all three lanes carry control characters, the two bits on each lane are routed to fixed outputs:

- Lane 0 supplies the horizontal and vertical sync.
- Lane 1 supplies user control bit 1. Its other bit is dropped.
- Lane 2 supplies user control bits 3 and 2.

A cycle in which the lanes disagree is treated as a fault. Every output keeps its previous value and a one-cycle error flag is raised. All outputs are registered, so each result appears one clock after its characters.

Top module: `tmds_char_decoder`

## Requirements
- R1: The pixel word is {red, green, blue}. Lane 2 (`sym_red`) drives bits [23:16], lane 1 (`sym_grn`) drives bits [15:8] and lane 0 (`sym_blu`) drives bits [7:0].
- R2: A colour character s[9:0] decodes in two steps:
  - First, q = s[9] ? ~s[7:0] : s[7:0].
  - Then bit 0 of the result is q[0], and each bit n from 1 to 7 is q[n]^q[n-1] when s[8]=1, or ~(q[n]^q[n-1]) when s[8]=0.
- R3: The control characters 10'b1101010100, 10'b0010101011, 10'b0101010100 and 10'b1010101011 decode to pairs {c1,c0} = 00, 01, 10 and 11. Any other 10-bit value is a colour character.
- R4: In blanking, lane 0's c0 drives `hsync` and its c1 drives `vsync`.
- R5: In blanking, lane 1's c1 drives `ctl[1]`. Lane 1's c0 affects no output.
- R6: In blanking, lane 2's c1 drives `ctl[3]` and its c0 drives `ctl[2]`.
- R7: `de` becomes 1 after a cycle in which all three lanes carry colour characters. It becomes 0 after a cycle in which all three carry control characters.
- R8: After a cycle in which the lanes carry a mix of the two classes, `mix_err` is 1 for one cycle and `pixel`, `de`, `hsync`, `vsync` and `ctl` keep their previous values. After any unmixed cycle, `mix_err` is 0.
- R9: `pixel` holds its last value while control characters arrive. `hsync`, `vsync` and `ctl` hold their last values while colour characters arrive.
- R10: Every output reflects the characters sampled at the previous rising clock edge, one cycle of latency.
- R11: A synchronous active-high `rst` sets `pixel`, `hsync`, `vsync`, `ctl`, `de` and `mix_err` to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_blu | input | 10 | Lane 0 character (blue / sync) |
| sym_grn | input | 10 | Lane 1 character (green / ctl1) |
| sym_red | input | 10 | Lane 2 character (red / ctl3, ctl2) |
| pixel | output | 24 | Decoded pixel, valid while `de` is 1 |
| de | output | 1 | Recovered data enable |
| hsync | output | 1 | Horizontal sync, valid while `de` is 0 |
| vsync | output | 1 | Vertical sync, valid while `de` is 0 |
| ctl | output | 3 | User control bits 3..1, valid while `de` is 0 |
| mix_err | output | 1 | One-cycle flag for a cycle with mixed character classes |

## Verification
The properties check on every cycle:
- the reset values;
- that a raised error flag leaves every other output frozen;
- that sync and control outputs stay still during active video;
- that the pixel word stays still during clean blanking.

Only the bench's scenarios can show the rest:
- the actual decode of colour values across every scramble variant;
- the full map from control characters to the sync and control outputs;
- the invisibility of lane 1's dropped bit;
- the exact one-cycle latency.

The bench does this by encoding known bytes and pairs and comparing against a behavioural model on every clock.

// File: rtl/tmds_char_decoder.sv
module tmds_char_decoder (
  input  logic        clk,
  input  logic        rst,
  input  logic [9:0]  sym_blu,
  input  logic [9:0]  sym_grn,
  input  logic [9:0]  sym_red,
  output logic [23:0] pixel,
  output logic        de,
  output logic        hsync,
  output logic        vsync,
  output logic [3:1]  ctl,
  output logic        mix_err
);

  localparam logic [9:0] KCH_00 = 10'b1101010100;
  localparam logic [9:0] KCH_01 = 10'b0010101011;
  localparam logic [9:0] KCH_10 = 10'b0101010100;
  localparam logic [9:0] KCH_11 = 10'b1010101011;

  function automatic logic is_ctl(input logic [9:0] s);
    return (s == KCH_00) || (s == KCH_01) || (s == KCH_10) || (s == KCH_11);
  endfunction

  function automatic logic ctl_lo(input logic [9:0] s);
    return (s == KCH_01) || (s == KCH_11);
  endfunction

  function automatic logic ctl_hi(input logic [9:0] s);
    return (s == KCH_10) || (s == KCH_11);
  endfunction

  function automatic logic [7:0] unscramble(input logic [9:0] s);
    logic [7:0] q;
    logic [7:0] d;
    q = s[9] ? ~s[7:0] : s[7:0];
    d[0] = q[0];
    for (int n = 1; n < 8; n++)
      d[n] = s[8] ? (q[n] ^ q[n-1]) : ~(q[n] ^ q[n-1]);
    return d;
  endfunction

  logic [2:0] kind;
  logic       all_data, all_ctl;

  assign kind     = {is_ctl(sym_red), is_ctl(sym_grn), is_ctl(sym_blu)};
  assign all_data = (kind == 3'b000);
  assign all_ctl  = (kind == 3'b111);

  always_ff @(posedge clk) begin
    if (rst) begin
      pixel   <= '0;
      de      <= 1'b0;
      hsync   <= 1'b0;
      vsync   <= 1'b0;
      ctl     <= '0;
      mix_err <= 1'b0;
    end else begin
      mix_err <= !(all_data || all_ctl);
      if (all_data) begin
        de    <= 1'b1;
        pixel <= {unscramble(sym_red), unscramble(sym_grn), unscramble(sym_blu)};
      end else if (all_ctl) begin
        de     <= 1'b0;
        hsync  <= ctl_lo(sym_blu);
        vsync  <= ctl_hi(sym_blu);
        ctl[1] <= ctl_hi(sym_grn);
        ctl[2] <= ctl_lo(sym_red);
        ctl[3] <= ctl_hi(sym_red);
      end
    end
  end

endmodule

module tmds_char_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic [23:0] pixel,
  input logic        de,
  input logic        hsync,
  input logic        vsync,
  input logic [3:1]  ctl,
  input logic        mix_err
);

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (pixel == 24'd0 && !de && !hsync && !vsync && ctl == 3'd0 && !mix_err));

  assert_err_freezes_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mix_err) |-> ($stable(pixel) && $stable(de) && $stable({hsync, vsync, ctl})));

  assert_ctl_hold_active_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && de) |-> $stable({hsync, vsync, ctl}));

  assert_pix_hold_blank_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !de) |-> $stable(pixel));

  assert_de_moves_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $changed(de)) |-> !mix_err);

endmodule

bind tmds_char_decoder tmds_char_decoder_chk u_chk (.*);

// File: tb/tmds_char_decoder_test.sv
module tmds_char_decoder_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [9:0]  s [3];
  logic [23:0] pixel;
  logic        de, hsync, vsync, mix_err;
  logic [3:1]  ctl;

  tmds_char_decoder uut (
    .clk(clk), .rst(rst),
    .sym_blu(s[0]), .sym_grn(s[1]), .sym_red(s[2]),
    .pixel(pixel), .de(de), .hsync(hsync), .vsync(vsync),
    .ctl(ctl), .mix_err(mix_err)
  );

  int         kind [3];
  logic [7:0] byt  [3];
  logic [1:0] pr   [3];

  logic [23:0] e_pix;
  logic        e_de, e_hs, e_vs, e_err;
  logic [3:1]  e_ctl;
  bit          started = 0;
  bit          done = 0;
  int          compared = 0;
  int          mismatched = 0;
  int          cycles = 0;
  string       cur_req = "R11";

  function automatic logic [9:0] kchar(input logic [1:0] p);
    case (p)
      2'b00:   return 10'b1101010100;
      2'b01:   return 10'b0010101011;
      2'b10:   return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  task automatic set_ctrl(input int ch, input logic [1:0] p);
    kind[ch] = 1;
    pr[ch]   = p;
    s[ch]    = kchar(p);
  endtask

  task automatic set_data(input int ch, input logic [7:0] b, input bit xn, input bit inv);
    logic [8:0] qm;
    logic [9:0] enc;
    qm[0] = b[0];
    for (int i = 1; i < 8; i++)
      qm[i] = xn ? ~(qm[i-1] ^ b[i]) : (qm[i-1] ^ b[i]);
    qm[8] = !xn;
    enc = {inv, qm[8], inv ? ~qm[7:0] : qm[7:0]};
    kind[ch] = 0;
    byt[ch]  = b;
    s[ch]    = enc;
    for (int p = 0; p < 4; p++)
      if (enc == kchar(2'(p))) begin
        kind[ch] = 1;
        pr[ch]   = 2'(p);
      end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic rand_data();
    for (int ch = 0; ch < 3; ch++)
      set_data(ch, 8'($urandom), 1'($urandom), 1'($urandom));
  endtask

  task automatic rand_ctrl();
    for (int ch = 0; ch < 3; ch++)
      set_ctrl(ch, 2'($urandom));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      e_pix = '0; e_de = 0; e_hs = 0; e_vs = 0; e_ctl = '0; e_err = 0;
    end else if (kind[0] + kind[1] + kind[2] == 0) begin
      e_de = 1; e_err = 0;
      e_pix = {byt[2], byt[1], byt[0]};
    end else if (kind[0] + kind[1] + kind[2] == 3) begin
      e_de = 0; e_err = 0;
      e_hs = pr[0][0]; e_vs = pr[0][1];
      e_ctl = {pr[2], pr[1][1]};
    end else begin
      e_err = 1;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      compared++;
      if (pixel !== e_pix || de !== e_de || hsync !== e_hs || vsync !== e_vs ||
          ctl !== e_ctl || mix_err !== e_err) begin
        mismatched++;
        $display("FAIL %s: got pix=%h de=%b hs=%b vs=%b ctl=%b err=%b exp pix=%h de=%b hs=%b vs=%b ctl=%b err=%b",
                 cur_req, pixel, de, hsync, vsync, ctl, mix_err,
                 e_pix, e_de, e_hs, e_vs, e_ctl, e_err);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: got %0d cycles exp completion", cycles);
      finish_run();
    end
  end

  initial begin
    rst = 1;
    for (int ch = 0; ch < 3; ch++) set_ctrl(ch, 2'b00);
    for (int ch = 0; ch < 3; ch++) byt[ch] = 8'h00;
    repeat (3) step();
    rst = 0;

    cur_req = "R11";
    step();

    cur_req = "R3 R4 R5 R6 R7";
    for (int a = 0; a < 64; a++) begin
      step();
      set_ctrl(0, 2'(a)); set_ctrl(1, 2'(a >> 2)); set_ctrl(2, 2'(a >> 4));
    end

    cur_req = "R5";
    for (int i = 0; i < 16; i++) begin
      step();
      set_ctrl(0, 2'b01); set_ctrl(2, 2'b10);
      set_ctrl(1, (i % 2) ? 2'b11 : 2'b10);
    end
    for (int i = 0; i < 16; i++) begin
      step();
      set_ctrl(1, (i % 2) ? 2'b01 : 2'b00);
    end

    cur_req = "R1 R2 R7";
    for (int i = 0; i < 1500; i++) begin
      step();
      rand_data();
    end

    cur_req = "R2";
    for (int bi = 0; bi < 8; bi++) begin
      logic [7:0] b;
      case (bi)
        0: b = 8'h00; 1: b = 8'hFF; 2: b = 8'h55; 3: b = 8'hAA;
        4: b = 8'h01; 5: b = 8'h80; 6: b = 8'h7F; default: b = 8'hFE;
      endcase
      for (int cmb = 0; cmb < 4; cmb++) begin
        step();
        for (int ch = 0; ch < 3; ch++)
          set_data(ch, b ^ 8'(ch), 1'(cmb ^ ch), 1'(cmb >> 1));
      end
    end

    cur_req = "R9";
    for (int i = 0; i < 400; i++) begin
      step();
      if ((i / 7) % 2 == 0) rand_data(); else rand_ctrl();
    end

    cur_req = "R8";
    step(); rand_data();
    step(); rand_data(); set_ctrl(1, 2'b11);
    step(); rand_ctrl(); set_data(2, 8'h3C, 1'b0, 1'b1);
    step(); rand_ctrl(); set_data(0, 8'hC3, 1'b1, 1'b0);
    step(); rand_ctrl();
    step(); rand_data(); set_ctrl(0, 2'b10);
    step(); rand_data();
    for (int i = 0; i < 800; i++) begin
      step();
      for (int ch = 0; ch < 3; ch++)
        if ($urandom % 2) set_data(ch, 8'($urandom), 1'($urandom), 1'($urandom));
        else set_ctrl(ch, 2'($urandom));
    end

    cur_req = "R10";
    for (int i = 0; i < 200; i++) begin
      step();
      if (i % 2) rand_data(); else rand_ctrl();
    end

    cur_req = "R11";
    step(); rand_data();
    step(); rand_ctrl(); rst = 1;
    step(); rand_data();
    step(); rst = 0; rand_ctrl();
    repeat (4) begin step(); rand_data(); end
    step();
    @(posedge clk);
    @(negedge clk);
    #1;
    finish_run();
  end

endmodule